// File: doc/BRIEF.md
# Three-Reel Slot Game Controller

This block runs a small button-driven slot game with three reels. A free-running counter advances on every clock cycle. A start pulse clears the game and sets every reel spinning. While a reel spins, its seven-segment output shows the symbol taken from the two low bits of the counter, so the display changes on every cycle.

Each reel has its own pick pulse. A pick freezes the reel on the counter's current value modulo four, and the reel holds that symbol until the next start. Once all three reels are stopped and show the same symbol, a win flag rises to light an indicator dot. The flag stays high until the next start.

A two-bit phase output reports whether no reel, some reels or all reels have stopped. Buttons arrive as synchronous one-cycle pulses. Debouncing and display multiplexing happen outside this block.

Top module: `slot_game_top`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are: all reels spinning, counter at zero, `seg_o` all zero, `win_o` low and `phase_o` equal to 0.
- R2: The internal counter increments by one, modulo 2^CNT_W, on every clock edge that is not in reset, whatever the buttons do.
- R3: A `start_i` pulse sets all reels spinning and clears `win_o` at the same edge.
- R4: A pick pulse `pick_i[k]` on a spinning reel k stops it and latches the counter's two low bits as its symbol, using the counter value from before that edge.
- R5: Symbol encoding on each 7-bit reel field, where bit 0 is segment a, bit 3 is segment d and bit 6 is segment g:
  - 0 gives 7'h00.
  - 1 gives 7'h40 (middle bar).
  - 2 gives 7'h41 (top and middle bars).
  - 3 gives 7'h49 (top, middle and bottom bars).
- R6: While reel k spins, its field `seg_o[7k+6:7k]` shows the encoding of the counter's two low bits as they were before each edge, so it changes every cycle.
- R7: A pick pulse on a reel that is already stopped has no effect on that reel's symbol.
- R8: A stopped reel keeps its symbol and display until the next start.
- R9: `win_o` rises one cycle after the edge at which the last of the three reels stops, when all three symbols are equal.
- R10: `win_o` stays low if the three symbols differ. Once high, it stays high until a start.
- R11: `phase_o` is 0 when all reels spin, 1 when some but not all reels are stopped, and 2 when all reels are stopped.
- R12: When start and a pick arrive in the same cycle, start wins: the reel keeps spinning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start or restart pulse |
| pick_i | input | 3 | Pick pulse per reel; bit k stops reel k |
| seg_o | output | 21 | Segment patterns; reel k is in bits [7k+6:7k] |
| win_o | output | 1 | Win indicator dot |
| phase_o | output | 2 | 0 = all spinning, 1 = partly stopped, 2 = all stopped |

## Verification
Segment outputs are registered, so a pick or start seen at an edge shows on `seg_o` and `phase_o` right after that same edge. `win_o` is judged from the registered reel states, so it follows one edge later. The bench's reference model applies these latencies edge by edge. Inputs are driven and outputs compared at the falling edge, half a cycle clear of the edges where they change.

// File: rtl/slot_pkg.sv
package slot_pkg;
  typedef enum logic [1:0] {
    PH_SPIN = 2'd0,
    PH_PART = 2'd1,
    PH_DONE = 2'd2
  } phase_e;

  localparam int SEG_W = 7;

  // bit0 = a (top), bit3 = d (bottom), bit6 = g (middle)
  function automatic logic [SEG_W-1:0] bars_of(input logic [1:0] sym);
    logic [SEG_W-1:0] p;
    p = '0;
    if (sym != 2'd0) p[6] = 1'b1;
    if (sym >= 2'd2) p[0] = 1'b1;
    if (sym == 2'd3) p[3] = 1'b1;
    return p;
  endfunction
endpackage

// File: rtl/slot_free_counter.sv
module slot_free_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/slot_reel.sv
module slot_reel
  import slot_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             pick_i,
  input  logic [1:0]       live_i,
  output logic [SEG_W-1:0] seg_o,
  output logic             stopped_o,
  output logic [1:0]       sym_o
);
  logic             spin_q;
  logic [1:0]       sym_q;
  logic [SEG_W-1:0] seg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      spin_q <= 1'b1;
      sym_q  <= '0;
      seg_q  <= '0;
    end else if (start_i) begin
      spin_q <= 1'b1;
      seg_q  <= bars_of(live_i);
    end else if (spin_q && pick_i) begin
      spin_q <= 1'b0;
      sym_q  <= live_i;
      seg_q  <= bars_of(live_i);
    end else if (spin_q) begin
      seg_q  <= bars_of(live_i);
    end else begin
      seg_q  <= bars_of(sym_q);
    end
  end

  assign seg_o     = seg_q;
  assign stopped_o = !spin_q;
  assign sym_o     = sym_q;

  a_r4_pick_stops: assert property (@(posedge clk) disable iff (rst)
    spin_q && pick_i && !start_i |=> !spin_q && sym_q == $past(live_i));
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !spin_q && !start_i |=> !spin_q && $stable(sym_q));
  a_r12_start_first: assert property (@(posedge clk) disable iff (rst)
    start_i |=> spin_q);
endmodule

// File: rtl/slot_win_judge.sv
module slot_win_judge #(
  parameter int N_REEL = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_i,
  input  logic [N_REEL-1:0]     stopped_i,
  input  logic [2*N_REEL-1:0]   sym_i,
  output logic                  win_o
);
  logic win_q;
  logic all_stop;
  logic all_same;

  always_comb begin
    all_stop = &stopped_i;
    all_same = 1'b1;
    for (int k = 1; k < N_REEL; k++)
      if (sym_i[2*k +: 2] != sym_i[1:0]) all_same = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || start_i)            win_q <= 1'b0;
    else if (all_stop && all_same) win_q <= 1'b1;
  end

  assign win_o = win_q;

  a_r10_win_sticky: assert property (@(posedge clk) disable iff (rst)
    win_q && !start_i |=> win_q);
  a_r9_win_needs_stop: assert property (@(posedge clk) disable iff (rst)
    win_q |-> all_stop);
  a_r3_start_clears: assert property (@(posedge clk) disable iff (rst)
    start_i |=> !win_q);
endmodule

// File: rtl/slot_game_top.sv
module slot_game_top
  import slot_pkg::*;
#(
  parameter int N_REEL = 3,
  parameter int CNT_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start_i,
  input  logic [N_REEL-1:0]       pick_i,
  output logic [SEG_W*N_REEL-1:0] seg_o,
  output logic                    win_o,
  output logic [1:0]              phase_o
);
  logic [CNT_W-1:0]    cnt;
  logic [N_REEL-1:0]   stopped;
  logic [2*N_REEL-1:0] syms;
  phase_e              phase;

  slot_free_counter #(.CNT_W(CNT_W)) ctr_i (
    .clk(clk), .rst(rst), .cnt_o(cnt)
  );

  for (genvar k = 0; k < N_REEL; k++) begin : g_reel
    slot_reel reel_i (
      .clk      (clk),
      .rst      (rst),
      .start_i  (start_i),
      .pick_i   (pick_i[k]),
      .live_i   (cnt[1:0]),
      .seg_o    (seg_o[SEG_W*k +: SEG_W]),
      .stopped_o(stopped[k]),
      .sym_o    (syms[2*k +: 2])
    );
  end

  slot_win_judge #(.N_REEL(N_REEL)) judge_i (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .stopped_i(stopped),
    .sym_i    (syms),
    .win_o    (win_o)
  );

  always_comb begin
    if (&stopped)      phase = PH_DONE;
    else if (|stopped) phase = PH_PART;
    else               phase = PH_SPIN;
  end

  assign phase_o = phase;

  a_r11_phase_legal: assert property (@(posedge clk) disable iff (rst)
    phase_o != 2'd3);
  a_r1_reset_spin: assert property (@(posedge clk)
    rst |=> stopped == '0 && !win_o);
endmodule

// File: tb/slot_game_top_tb_top.sv
module slot_game_top_tb_top;
  localparam int N = 3;
  logic clk = 1'b0;
  logic rst, start_i;
  logic [N-1:0] pick_i;
  logic [7*N-1:0] seg_o;
  logic win_o;
  logic [1:0] phase_o;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  slot_game_top dut_i (.clk(clk), .rst(rst), .start_i(start_i), .pick_i(pick_i),
                       .seg_o(seg_o), .win_o(win_o), .phase_o(phase_o));

  // reference model
  int m_cnt;
  bit m_spin[N];
  int m_sym[N];
  logic [6:0] m_seg[N];
  bit m_win;

  function automatic logic [6:0] enc(int s);
    case (s)
      0: return 7'h00;
      1: return 7'h40;
      2: return 7'h41;
      default: return 7'h49;
    endcase
  endfunction

  always @(posedge clk) begin
    bit all_st, same;
    if (rst) begin
      m_cnt = 0; m_win = 0;
      for (int k = 0; k < N; k++) begin m_spin[k] = 1; m_sym[k] = 0; m_seg[k] = 0; end
    end else begin
      all_st = 1; same = 1;
      for (int k = 0; k < N; k++) begin
        if (m_spin[k]) all_st = 0;
        if (m_sym[k] != m_sym[0]) same = 0;
      end
      if (start_i) m_win = 0;
      else if (all_st && same) m_win = 1;
      for (int k = 0; k < N; k++) begin
        if (start_i) begin m_spin[k] = 1; m_seg[k] = enc(m_cnt % 4); end
        else if (m_spin[k] && pick_i[k]) begin
          m_spin[k] = 0; m_sym[k] = m_cnt % 4; m_seg[k] = enc(m_cnt % 4);
        end else if (m_spin[k]) m_seg[k] = enc(m_cnt % 4);
        else m_seg[k] = enc(m_sym[k]);
      end
      m_cnt = (m_cnt + 1) % 256;
    end
  end

  function automatic int m_phase();
    int st = 0;
    for (int k = 0; k < N; k++) if (!m_spin[k]) st++;
    return (st == 0) ? 0 : (st == N) ? 2 : 1;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    for (int k = 0; k < N; k++)
      chk("R2,R4,R5,R6,R7,R8 seg", seg_o[7*k +: 7], m_seg[k]);
    chk("R9,R10 win", win_o, m_win);
    chk("R11 phase", phase_o, m_phase());
  endtask

  task automatic step(bit s, logic [N-1:0] p);
    start_i = s; pick_i = p;
    @(posedge clk); @(negedge clk);
    start_i = 0; pick_i = '0;
    compare_all();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, '0);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst = 1; start_i = 0; pick_i = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 seg", seg_o, '0); chk("R1 win", win_o, 0); chk("R1 phase", phase_o, 0);
    rst = 0;
    idle(9);
    // staggered picks, mismatch
    step(0, 3'b001); chk("R11 partial", phase_o, 1);
    step(0, 3'b010);
    idle(2);
    step(0, 3'b001); // R7 repick ignored
    step(0, 3'b100); chk("R11 done", phase_o, 2);
    idle(3); chk("R10 no win on mismatch", win_o, 0);
    // equal symbols via 4-cycle spacing
    step(1, '0); chk("R3 restart", phase_o, 0);
    step(0, 3'b001); idle(3);
    step(0, 3'b010); idle(3);
    step(0, 3'b100);
    step(0, '0); chk("R9 win", win_o, 1);
    idle(6); chk("R10 win held", win_o, 1);
    step(0, 3'b111); chk("R8 still win", win_o, 1);
    // start with pick same cycle
    step(1, 3'b111); chk("R12 start wins", phase_o, 0); chk("R3 win cleared", win_o, 0);
    step(0, 3'b111); step(0, '0); chk("R9 simultaneous win", win_o, 1);
    // varied pattern
    step(1, '0); idle(5);
    step(0, 3'b100); idle(1); step(0, 3'b001); idle(2); step(0, 3'b010);
    idle(4);
    // counter wrap
    step(1, '0); idle(300);
    step(0, 3'b010); idle(1); step(0, 3'b101); idle(3);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule